// File: doc/BRIEF.md
# Segmented Paging Address Translator

This block turns a 24-bit virtual address into a 24-bit physical address in two stages. The top four bits select one of sixteen segment registers. Each register says whether the segment exists, where its page table starts in memory, and how many entries that table holds. The middle eight bits pick an entry in that table. The block fetches the entry through a simple memory read port, checks its valid bit, and joins the 12-bit frame number with the untouched 12-bit page offset.

The block handles one translation at a time. A request is accepted only while the block is idle. A small state machine checks the segment, bounds-checks the page number, issues one read, waits any number of cycles for the response, and then reports the result for exactly one cycle. A missing segment and an out-of-range page number are caught before memory is touched. The fault code tells these two cases apart from a fetched entry whose valid bit is clear. Software loads the segment registers through a write port.

Top module: `seg_page_xlate`

## Requirements
- R1: A successful translation returns `xl_paddr = {frame, offset}`, where frame is bits [11:0] of the fetched entry and offset is `xl_vaddr[11:0]` unchanged. The segment is `xl_vaddr[23:20]` and the page number is `xl_vaddr[19:12]`.
- R2: A translation that passes the segment and bounds checks issues exactly one read, `mem_req` high for one cycle, at address `(base + 2*page) mod 2^16`.
- R3: If the page number is not below the segment's table length (`cfg_pt_len`, 0..256), the result is fault code 2 and no read is issued.
- R4: An access to a segment whose present flag is clear gives fault code 1 and no read.
- R5: A fetched entry with bit 15 clear gives fault code 3. Any faulting result drives `xl_paddr` to zero.
- R6: After reset, every segment is absent, and `xl_busy`, `xl_done` and `mem_req` are low.
- R7: Read latency may be any number of cycles from one upward. A `mem_rvalid` that arrives while no read is outstanding is ignored.
- R8: `xl_req` is ignored while `xl_busy` is high. It neither changes the result in flight nor starts a second translation.
- R9: A segment-register write in the same cycle that a request is accepted is seen by that request.
- R10: `xl_done` is a one-cycle pulse. Fault code 0 marks success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Segment register write strobe |
| cfg_seg | input | 4 | Segment register being written |
| cfg_present | input | 1 | Segment exists |
| cfg_pt_base | input | 16 | Page-table start address |
| cfg_pt_len | input | 9 | Number of page-table entries |
| xl_req | input | 1 | Start a translation (taken when idle) |
| xl_vaddr | input | 24 | Virtual address |
| xl_busy | output | 1 | Translation in progress |
| xl_done | output | 1 | Result valid this cycle |
| xl_paddr | output | 24 | Physical address (zero on fault) |
| xl_fault | output | 2 | 0 ok, 1 no segment, 2 page beyond table, 3 entry invalid |
| mem_req | output | 1 | Page-table read request |
| mem_addr | output | 16 | Page-table entry address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Page-table entry: bit 15 valid, [11:0] frame |

## Verification
Two things can land in the same cycle: a segment-register write and the acceptance of a translation. The design must let the new register contents govern that translation. The bench provokes this by writing an absent segment as present in the very cycle it raises `xl_req` for an address in that segment. It then expects a successful result, with the read address formed from the newly written base. A second overlap is a stray `mem_rvalid` pulse in the cycle the segment check runs. The bench drives one on every third translation of an exhaustive sweep over all segments and page numbers, and judges each result against its own arithmetic model.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_SEG  = 2'd1,
    FLT_LEN  = 2'd2,
    FLT_PTE  = 2'd3
  } xl_fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEG_CHECK,
    ST_PT_READ,
    ST_WAIT_RESP,
    ST_DONE
  } xl_state_e;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int SEG_W = 4,
  parameter int MA_W  = 16,
  parameter int LEN_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_idx,
  input  logic             wr_present,
  input  logic [MA_W-1:0]  wr_base,
  input  logic [LEN_W-1:0] wr_len,
  input  logic [SEG_W-1:0] rd_idx,
  output logic             rd_present,
  output logic [MA_W-1:0]  rd_base,
  output logic [LEN_W-1:0] rd_len
);
  localparam int NSEG = 1 << SEG_W;

  logic             present_a [NSEG];
  logic [MA_W-1:0]  base_a    [NSEG];
  logic [LEN_W-1:0] len_a     [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_ent
    logic             present_q;
    logic [MA_W-1:0]  base_q;
    logic [LEN_W-1:0] len_q;
    wire              hit = wr_en && (wr_idx == SEG_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        present_q <= 1'b0;
        base_q    <= '0;
        len_q     <= '0;
      end else if (hit) begin
        present_q <= wr_present;
        base_q    <= wr_base;
        len_q     <= wr_len;
      end
    end

    assign present_a[g] = present_q;
    assign base_a[g]    = base_q;
    assign len_a[g]     = len_q;
  end

  assign rd_present = present_a[rd_idx];
  assign rd_base    = base_a[rd_idx];
  assign rd_len     = len_a[rd_idx];

endmodule

// File: rtl/pte_decode.sv
module pte_decode #(
  parameter int PTE_W   = 16,
  parameter int PTE_VLD = 15,
  parameter int FRAME_W = 12,
  parameter int OFF_W   = 12
) (
  input  logic [PTE_W-1:0]         pte_i,
  input  logic [OFF_W-1:0]         off_i,
  output logic                     ok_o,
  output logic [FRAME_W+OFF_W-1:0] paddr_o
);
  function automatic logic [FRAME_W+OFF_W-1:0] join_frame(
    input logic [FRAME_W-1:0] frame,
    input logic [OFF_W-1:0]   off);
    return {frame, off};
  endfunction

  assign ok_o    = pte_i[PTE_VLD];
  assign paddr_o = join_frame(pte_i[FRAME_W-1:0], off_i);

endmodule

// File: rtl/xlate_fsm.sv
module xlate_fsm
  import xlate_pkg::*;
#(
  parameter int SEG_W   = 4,
  parameter int VPN_W   = 8,
  parameter int OFF_W   = 12,
  parameter int MA_W    = 16,
  parameter int FRAME_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_i,
  input  logic [SEG_W+VPN_W+OFF_W-1:0] vaddr_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic [FRAME_W+OFF_W-1:0] paddr_o,
  output logic [1:0]               fault_o,
  output logic [SEG_W-1:0]         seg_idx_o,
  output logic [OFF_W-1:0]         off_o,
  input  logic                     seg_present_i,
  input  logic [MA_W-1:0]          seg_base_i,
  input  logic [VPN_W:0]           seg_len_i,
  output logic                     mem_req_o,
  output logic [MA_W-1:0]          mem_addr_o,
  input  logic                     mem_rvalid_i,
  input  logic                     pte_ok_i,
  input  logic [FRAME_W+OFF_W-1:0] pte_paddr_i
);
  localparam int VA_W = SEG_W + VPN_W + OFF_W;
  localparam int PA_W = FRAME_W + OFF_W;

  function automatic logic [MA_W-1:0] entry_addr(
    input logic [MA_W-1:0]  base,
    input logic [VPN_W-1:0] vpn);
    return base + (MA_W'(vpn) << 1);
  endfunction

  xl_state_e        state_q;
  logic [VA_W-1:0]  vaddr_q;
  logic [MA_W-1:0]  addr_q;
  logic [PA_W-1:0]  paddr_q;
  xl_fault_e        fault_q;
  logic [VPN_W-1:0] vpn;

  assign vpn = vaddr_q[OFF_W +: VPN_W];

  // named events for the assertions
  wire ev_accept   = (state_q == ST_IDLE) && req_i;
  wire ev_seg_miss = (state_q == ST_SEG_CHECK) && !seg_present_i;
  wire ev_len_ovf  = (state_q == ST_SEG_CHECK) && seg_present_i
                     && ({1'b0, vpn} >= seg_len_i);
  wire ev_resp     = (state_q == ST_WAIT_RESP) && mem_rvalid_i;
  wire ev_pte_bad  = ev_resp && !pte_ok_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      vaddr_q <= '0;
      addr_q  <= '0;
      paddr_q <= '0;
      fault_q <= FLT_NONE;
    end else begin
      case (state_q)
        ST_IDLE: if (ev_accept) begin
          vaddr_q <= vaddr_i;
          state_q <= ST_SEG_CHECK;
        end
        ST_SEG_CHECK: begin
          if (ev_seg_miss) begin
            fault_q <= FLT_SEG;
            paddr_q <= '0;
            state_q <= ST_DONE;
          end else if (ev_len_ovf) begin
            fault_q <= FLT_LEN;
            paddr_q <= '0;
            state_q <= ST_DONE;
          end else begin
            addr_q  <= entry_addr(seg_base_i, vpn);
            state_q <= ST_PT_READ;
          end
        end
        ST_PT_READ: state_q <= ST_WAIT_RESP;
        ST_WAIT_RESP: if (ev_resp) begin
          fault_q <= ev_pte_bad ? FLT_PTE : FLT_NONE;
          paddr_q <= ev_pte_bad ? '0 : pte_paddr_i;
          state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);
  assign paddr_o    = paddr_q;
  assign fault_o    = fault_q;
  assign seg_idx_o  = vaddr_q[VA_W-1 -: SEG_W];
  assign off_o      = vaddr_q[OFF_W-1:0];
  assign mem_req_o  = (state_q == ST_PT_READ);
  assign mem_addr_o = addr_q;

  AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |=> !mem_req_o); // R2
  AST_LEN_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ev_len_ovf |=> (!mem_req_o && done_o && fault_o == FLT_LEN)); // R3
  AST_SEG_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ev_seg_miss |=> (!mem_req_o && done_o && fault_o == FLT_SEG)); // R4
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && fault_o != FLT_NONE) |-> (paddr_o == '0)); // R5
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && fault_o == FLT_NONE) |-> (paddr_o[OFF_W-1:0] == off_o)); // R1
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && req_i) |=> $stable(vaddr_q)); // R8
  AST_STRAY_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rvalid_i && state_q == ST_SEG_CHECK && !ev_seg_miss && !ev_len_ovf)
    |=> mem_req_o); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o)); // R10

endmodule

// File: rtl/seg_page_xlate.sv
module seg_page_xlate
  import xlate_pkg::*;
#(
  parameter int SEG_W   = 4,
  parameter int VPN_W   = 8,
  parameter int OFF_W   = 12,
  parameter int MA_W    = 16,
  parameter int PTE_W   = 16,
  parameter int PTE_VLD = 15,
  parameter int FRAME_W = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [SEG_W-1:0]              cfg_seg,
  input  logic                          cfg_present,
  input  logic [MA_W-1:0]               cfg_pt_base,
  input  logic [VPN_W:0]                cfg_pt_len,
  input  logic                          xl_req,
  input  logic [SEG_W+VPN_W+OFF_W-1:0]  xl_vaddr,
  output logic                          xl_busy,
  output logic                          xl_done,
  output logic [FRAME_W+OFF_W-1:0]      xl_paddr,
  output logic [1:0]                    xl_fault,
  output logic                          mem_req,
  output logic [MA_W-1:0]               mem_addr,
  input  logic                          mem_rvalid,
  input  logic [PTE_W-1:0]              mem_rdata
);
  localparam int LEN_W = VPN_W + 1;
  localparam int PA_W  = FRAME_W + OFF_W;

  logic [SEG_W-1:0] seg_idx;
  logic             seg_present;
  logic [MA_W-1:0]  seg_base;
  logic [LEN_W-1:0] seg_len;
  logic [OFF_W-1:0] cur_off;
  logic             pte_ok;
  logic [PA_W-1:0]  pte_paddr;

  seg_table #(.SEG_W(SEG_W), .MA_W(MA_W), .LEN_W(LEN_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_idx(cfg_seg), .wr_present(cfg_present),
    .wr_base(cfg_pt_base), .wr_len(cfg_pt_len),
    .rd_idx(seg_idx), .rd_present(seg_present), .rd_base(seg_base),
    .rd_len(seg_len)
  );

  pte_decode #(.PTE_W(PTE_W), .PTE_VLD(PTE_VLD), .FRAME_W(FRAME_W),
               .OFF_W(OFF_W)) u_pte (
    .pte_i(mem_rdata), .off_i(cur_off), .ok_o(pte_ok), .paddr_o(pte_paddr)
  );

  xlate_fsm #(.SEG_W(SEG_W), .VPN_W(VPN_W), .OFF_W(OFF_W), .MA_W(MA_W),
              .FRAME_W(FRAME_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_i(xl_req), .vaddr_i(xl_vaddr),
    .busy_o(xl_busy), .done_o(xl_done), .paddr_o(xl_paddr),
    .fault_o(xl_fault),
    .seg_idx_o(seg_idx), .off_o(cur_off),
    .seg_present_i(seg_present), .seg_base_i(seg_base), .seg_len_i(seg_len),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
    .pte_ok_i(pte_ok), .pte_paddr_i(pte_paddr)
  );

endmodule

// File: tb/test_seg_page_xlate.sv
`timescale 1ns/1ps
module test_seg_page_xlate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_seg = '0;
  logic        cfg_present = 1'b0;
  logic [15:0] cfg_pt_base = '0;
  logic [8:0]  cfg_pt_len = '0;
  logic        xl_req = 1'b0;
  logic [23:0] xl_vaddr = '0;
  logic        xl_busy, xl_done, mem_req;
  logic [23:0] xl_paddr;
  logic [1:0]  xl_fault;
  logic [15:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [15:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;

  logic [15:0] m_base [16];
  int          m_len  [16];
  bit          m_on   [16];

  always #4 clk = ~clk;

  seg_page_xlate i_seg_page_xlate (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_seg(cfg_seg), .cfg_present(cfg_present),
    .cfg_pt_base(cfg_pt_base), .cfg_pt_len(cfg_pt_len),
    .xl_req(xl_req), .xl_vaddr(xl_vaddr),
    .xl_busy(xl_busy), .xl_done(xl_done), .xl_paddr(xl_paddr),
    .xl_fault(xl_fault),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  function automatic logic [15:0] mem_word(input logic [15:0] a);
    logic       v;
    logic [11:0] fr;
    v  = (((a >> 1) % 5) != 2);
    fr = 12'((a * 3) + 16'h0015);
    return {v, 3'b101, fr};
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input int s, input bit on,
                           input logic [15:0] b, input int len);
    @(negedge clk);
    cfg_we = 1'b1; cfg_seg = 4'(s); cfg_present = on;
    cfg_pt_base = b; cfg_pt_len = 9'(len);
    m_on[s] = on; m_base[s] = b; m_len[s] = len;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // waits for the result; starts right after the accepting edge
  task automatic wait_result(input logic [23:0] va, input int lat,
                             input bit poke,
                             output logic [1:0] f, output logic [23:0] pa,
                             output int nreads, output logic [15:0] raddr,
                             output bit got);
    nreads = 0; got = 0; f = '0; pa = '0; raddr = '0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (xl_done) begin
        got = 1; f = xl_fault; pa = xl_paddr;
        break;
      end
      if (mem_req) begin
        nreads++;
        raddr = mem_addr;
        if (poke) begin xl_req = 1'b1; xl_vaddr = ~va; end
        repeat (lat) @(negedge clk);
        xl_req = 1'b0;
        mem_rvalid = 1'b1;
        mem_rdata = mem_word(raddr);
      end
    end
  endtask

  task automatic run_xl(input logic [23:0] va, input int lat,
                        input bit stray, input bit poke,
                        output logic [1:0] f, output logic [23:0] pa,
                        output int nreads, output logic [15:0] raddr,
                        output bit got);
    @(negedge clk);
    xl_req = 1'b1; xl_vaddr = va;
    @(negedge clk);
    xl_req = 1'b0;
    if (stray) begin mem_rvalid = 1'b1; mem_rdata = 16'h8ABC; end
    wait_result(va, lat, poke, f, pa, nreads, raddr, got);
  endtask

  task automatic judge(input logic [23:0] va, input logic [1:0] f,
                       input logic [23:0] pa, input int nreads,
                       input logic [15:0] raddr, input bit got);
    int          s, v;
    logic [15:0] ea;
    logic [15:0] w;
    s = int'(va[23:20]); v = int'(va[19:12]);
    ea = 16'(m_base[s] + 16'(2 * v));
    chk(got, "R10 done", 32'(got), 1);
    if (!m_on[s]) begin
      chk(f == 2'd1, "R4 fault", 32'(f), 1);
      chk(nreads == 0, "R4 reads", 32'(nreads), 0);
    end else if (v >= m_len[s]) begin
      chk(f == 2'd2, "R3 fault", 32'(f), 2);
      chk(nreads == 0, "R3 reads", 32'(nreads), 0);
    end else begin
      w = mem_word(ea);
      chk(nreads == 1, "R2 reads", 32'(nreads), 1);
      chk(raddr == ea, "R2 address", 32'(raddr), 32'(ea));
      if (!w[15]) begin
        chk(f == 2'd3, "R5 fault", 32'(f), 3);
        chk(pa == '0, "R5 paddr", 32'(pa), 0);
      end else begin
        chk(f == 2'd0, "R10 fault", 32'(f), 0);
        chk(pa == {w[11:0], va[11:0]}, "R1 paddr", 32'(pa),
            32'({w[11:0], va[11:0]}));
      end
    end
  endtask

  initial begin : watchdog
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [1:0]  f;
    logic [23:0] pa;
    int          nr;
    logic [15:0] ra;
    bit          got;
    logic [23:0] va;

    for (int s = 0; s < 16; s++) begin
      m_on[s] = 0; m_base[s] = '0; m_len[s] = 0;
    end
    repeat (3) @(negedge clk);
    chk(!xl_busy && !xl_done && !mem_req, "R6 reset outputs",
        {29'd0, xl_busy, xl_done, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!xl_busy && !xl_done && !mem_req, "R6 after reset",
        {29'd0, xl_busy, xl_done, mem_req}, 0);
    va = {4'd5, 8'd1, 12'h123};
    run_xl(va, 1, 0, 0, f, pa, nr, ra, got);
    chk(f == 2'd1 && nr == 0, "R6 segments absent", 32'(f), 1);

    // segment layout: 3, 8, 13 absent; 0 has an empty table; 15 full
    for (int s = 0; s < 16; s++) begin
      int len;
      len = (s == 0) ? 0 : (s == 15) ? 256 : ((s * 29 + 3) % 256);
      cfg_write(s, (s % 5) != 3, 16'(16'h0200 * s + 16'h0040), len);
    end

    // exhaustive sweep: R1 R2 R3 R4 R5 R7 (stray response, latency 1..4)
    for (int s = 0; s < 16; s++) begin
      for (int v = 0; v < 256; v++) begin
        logic [11:0] off;
        off = 12'(s * 613 + v * 97);
        va = {4'(s), 8'(v), off};
        run_xl(va, 1 + ((s + v) % 4), (v % 3) == 0, 0, f, pa, nr, ra, got);
        judge(va, f, pa, nr, ra, got);
      end
    end

    // R7 long latency, R8 requests while busy are ignored
    va = {4'd15, 8'd200, 12'hFED};
    run_xl(va, 9, 1, 1, f, pa, nr, ra, got);
    judge(va, f, pa, nr, ra, got);
    @(negedge clk);
    chk(!xl_done && !xl_busy, "R10 pulse / R8 no second start",
        {30'd0, xl_done, xl_busy}, 0);
    begin
      bit extra;
      extra = 0;
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        if (xl_done || xl_busy || mem_req) extra = 1;
      end
      chk(!extra, "R8 no extra translation", 32'(extra), 0);
    end

    // R9 write and accept in the same cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_seg = 4'd3; cfg_present = 1'b1;
    cfg_pt_base = 16'h7000; cfg_pt_len = 9'd10;
    m_on[3] = 1; m_base[3] = 16'h7000; m_len[3] = 10;
    va = {4'd3, 8'd5, 12'h0AB};
    xl_req = 1'b1; xl_vaddr = va;
    @(negedge clk);
    cfg_we = 1'b0; xl_req = 1'b0;
    wait_result(va, 2, 0, f, pa, nr, ra, got);
    chk(nr == 1 && ra == 16'h700A, "R9 new base used", 32'(ra), 32'h700A);
    judge(va, f, pa, nr, ra, got);

    // R9 removing a segment in the accepting cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_seg = 4'd3; cfg_present = 1'b0;
    m_on[3] = 0;
    xl_req = 1'b1; xl_vaddr = va;
    @(negedge clk);
    cfg_we = 1'b0; xl_req = 1'b0;
    wait_result(va, 1, 0, f, pa, nr, ra, got);
    chk(f == 2'd1 && nr == 0, "R9 removal seen", 32'(f), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule